// File: doc/BRIEF.md
# SAR Conversion Sequencer with Bus-Activity Slip

This block is the digital control sequencer of a 12-bit successive-approximation converter. Once a start edge is accepted it leaves track mode and runs thirteen comparator decisions, each spanning four converter clocks. Twelve of them resolve the data bits, most significant first. The thirteenth checks whether the held input lies outside the convertible span. A final four-clock cycle then moves the two's-complement result and its range flag into the FIFO, and the block returns to track.

The analog comparator and DAC sit outside this block. The block presents the trial code, and a single comparator input reports the decision back. Host bus accesses can couple noise into a decision. For that reason, the chip-select, read and write lines are sampled on the falling clock edge. A decision edge that follows a low-phase access is then pushed back by one whole clock, and this repeats for as long as the access continues. An idle bus gives a conversion of 56 clocks. Each interfering clock adds one.

Top module: `sar_sequencer`

## Requirements
- R1: After synchronous active-low reset, `track_o` is 1, and `fifo_wr_o`, `proto_err_o`, `result_o` and `result_oor_o` are all 0.
- R2: A low-to-high change of `start_i` seen at a rising clock edge while tracking starts a conversion. From that edge `track_o` is 0 and `trial_code_o` is 0x800 (offset binary, only the MSB set).
- R3: Twelve decisions resolve the bits MSB first. `cmp_i`=1 keeps the bit under trial and `cmp_i`=0 clears it, and the next lower bit is set as the new trial. `result_o` is the final offset-binary code with its MSB inverted (two's complement).
- R4: The thirteenth decision is the range trial, and `range_trial_o` is 1 while it is pending. `result_oor_o` is 1 only when `cmp_i` is 1 at that decision and the final code is all ones or all zeros.
- R5: With no bus activity, decisions fall on every fourth rising edge after the start edge, the first one at the fourth. `fifo_wr_o` is high after the 56th rising edge following the start edge.
- R6: If `cs_n` is 0 together with `rd_n`=0 or `wr_n`=0 at the falling edge just before a decision edge, that decision moves one clock later. The check repeats at each later edge, and each such clock adds exactly one clock to the conversion.
- R7: Bus activity has no effect on timing or result when it precedes an edge that is not a decision edge, when it falls in the transfer cycle, or when `cs_n` is 1.
- R8: `fifo_wr_o` is a one-clock pulse. In the same cycle `track_o` returns to 1 and `result_o`/`result_oor_o` show the new conversion.
- R9: A start edge during a conversion is ignored, leaving timing and result unchanged, and it sets `proto_err_o`. That flag stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Convert start; rising edge begins a conversion |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| cmp_i | input | 1 | Comparator decision for the current trial |
| trial_code_o | output | 12 | Offset-binary code under trial (drives the DAC) |
| range_trial_o | output | 1 | Range trial pending |
| result_o | output | 12 | Last result, two's complement |
| result_oor_o | output | 1 | Last result out of range |
| fifo_wr_o | output | 1 | One-clock FIFO write strobe |
| track_o | output | 1 | High while tracking (idle), low during conversion |
| proto_err_o | output | 1 | Sticky: start seen while converting |

## Verification
The bench builds the block at its defaults, 12 bits and 4 clocks per trial, so its expected clock counts are 56 plus the number of slipped clocks. Those defaults make the full-scale codes 0x000 and 0xFFF reachable with a short bench comparator model, and this exposes the range trial at both extremes and at a mid-scale code. Bus patterns place access windows on decision edges, between them, across one decision for five clocks, on every decision (69 clocks), in the transfer cycle and with chip select high. This separates a correct one-clock slip from an off-by-one or an unwanted slip.

// File: rtl/sar_seq_pkg.sv
// Shared types for the SAR sequencer.
package sar_seq_pkg;
    // Sequencer phases: tracking (idle), bit trials, result transfer.
    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_TRIAL = 2'd1,
        ST_XFER  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/sar_bus_guard.sv
// Samples host bus activity on the falling clock edge.
// Assumes: cs_n/rd_n/wr_n are synchronous to clk (common clock source).
// The registered flag is read by the decision logic at the next rising edge.
module sar_bus_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic bus_busy_o
);
    // Capture "chip selected with read or write" in the clock-low phase.
    always_ff @(negedge clk) begin
        if (!rst_n) bus_busy_o <= 1'b0;
        else        bus_busy_o <= ~cs_n & (~rd_n | ~wr_n);
    end
endmodule

// File: rtl/sar_timebase.sv
// Divides the converter clock into trial periods of PHASES clocks.
// A decision edge is held off one clock at a time while slip_en and
// bus_busy are both high. Assumes PHASES >= 2.
module sar_timebase #(
    parameter int PHASES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic slip_en,
    input  logic bus_busy,
    output logic tick_o
);
    localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(PHASES - 1);

    logic [PW-1:0] ph;
    logic          hold;

    // Hold the final phase while an access is pending on a decision edge.
    assign hold   = slip_en & bus_busy;
    assign tick_o = run & (ph == PH_LAST) & ~hold;

    // Phase counter: clears on a new start, wraps after each accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       ph <= '0;
        else if (restart) ph <= '0;
        else if (run) begin
            if (ph != PH_LAST) ph <= ph + 1'b1;
            else if (!hold)    ph <= '0;
        end
    end

    // R6
    slip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && ph == PH_LAST && slip_en && bus_busy) |=> (ph == PH_LAST));

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !restart) |=> !tick_o);
endmodule

// File: rtl/sar_datapath.sv
// Successive-approximation register, range flag and result capture.
// The trial code is offset binary; the captured result is two's complement.
// Assumes decide only while idx < NBITS and range_decide after the last bit.
module sar_datapath #(
    parameter int NBITS = 12,
    parameter int IW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             decide,
    input  logic             range_decide,
    input  logic             commit,
    input  logic [IW-1:0]    idx,
    input  logic             cmp_i,
    output logic [NBITS-1:0] code_o,
    output logic [NBITS-1:0] result_o,
    output logic             oor_o
);
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};
    localparam logic [NBITS-1:0] POS_FULL = {1'b0, {(NBITS-1){1'b1}}};

    logic [NBITS-1:0] sel;
    logic [NBITS-1:0] sel_next;
    logic             oor_q;

    // One-hot of the bit under trial and of the bit tried next.
    assign sel      = MSB_ONLY >> idx;
    assign sel_next = sel >> 1;

    // One register slice per bit: keep/clear on its decision, set when next.
    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)          code_o[b] <= 1'b0;
            else if (clear)      code_o[b] <= (b == NBITS - 1);
            else if (decide) begin
                if (sel[b])           code_o[b] <= cmp_i;
                else if (sel_next[b]) code_o[b] <= 1'b1;
            end
        end
    end

    // Range trial: only meaningful when the code sits at a full-scale end.
    always_ff @(posedge clk) begin
        if (!rst_n)            oor_q <= 1'b0;
        else if (clear)        oor_q <= 1'b0;
        else if (range_decide) oor_q <= cmp_i & ((&code_o) | ~(|code_o));
    end

    // Result capture into the FIFO-facing register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            oor_o    <= 1'b0;
        end else if (commit) begin
            result_o <= {~code_o[NBITS-1], code_o[NBITS-2:0]};
            oor_o    <= oor_q;
        end
    end

    // R2
    clear_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (code_o == MSB_ONLY));

    // R4
    oor_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oor_o |-> (result_o == POS_FULL || result_o == MSB_ONLY));
endmodule

// File: rtl/sar_sequencer.sv
// SAR conversion sequencer: NBITS data trials, one range trial and one
// transfer period, each PHASES clocks long. Decision edges slip while the
// host bus is active in the low phase before them.
// Assumes start_i, bus lines and clk come from one clock domain.
module sar_sequencer #(
    parameter int NBITS  = 12,
    parameter int PHASES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             cmp_i,
    output logic [NBITS-1:0] trial_code_o,
    output logic             range_trial_o,
    output logic [NBITS-1:0] result_o,
    output logic             result_oor_o,
    output logic             fifo_wr_o,
    output logic             track_o,
    output logic             proto_err_o
);
    import sar_seq_pkg::*;

    localparam int IW = $clog2(NBITS + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(NBITS);

    seq_state_t    state;
    logic [IW-1:0] idx;
    logic          start_q;
    logic          start_edge;
    logic          accept;
    logic          bus_busy;
    logic          tick;
    logic          in_trial;
    logic          in_xfer;
    logic          decide;
    logic          range_decide;
    logic          commit;

    assign start_edge   = start_i & ~start_q;
    assign accept       = start_edge & (state == ST_TRACK);
    assign in_trial     = (state == ST_TRIAL);
    assign in_xfer      = (state == ST_XFER);
    assign decide       = in_trial & tick & (idx != LAST_IDX);
    assign range_decide = in_trial & tick & (idx == LAST_IDX);
    assign commit       = in_xfer & tick;
    assign track_o      = (state == ST_TRACK);
    assign range_trial_o = in_trial & (idx == LAST_IDX);

    sar_bus_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .bus_busy_o (bus_busy)
    );

    sar_timebase #(.PHASES(PHASES)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .run      (!track_o),
        .slip_en  (in_trial),
        .bus_busy (bus_busy),
        .tick_o   (tick)
    );

    sar_datapath #(.NBITS(NBITS), .IW(IW)) u_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (accept),
        .decide       (decide),
        .range_decide (range_decide),
        .commit       (commit),
        .idx          (idx),
        .cmp_i        (cmp_i),
        .code_o       (trial_code_o),
        .result_o     (result_o),
        .oor_o        (result_oor_o)
    );

    // Start edge detector register.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start_i;
    end

    // Sequencer state and trial index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_TRACK;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_TRACK: if (accept) begin
                    state <= ST_TRIAL;
                    idx   <= '0;
                end
                ST_TRIAL: if (tick) begin
                    if (idx == LAST_IDX) state <= ST_XFER;
                    else                 idx   <= idx + 1'b1;
                end
                ST_XFER:  if (tick) state <= ST_TRACK;
                default:  state <= ST_TRACK;
            endcase
        end
    end

    // FIFO write strobe, one clock after the transfer period ends.
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_wr_o <= 1'b0;
        else        fifo_wr_o <= commit;
    end

    // Sticky flag for a start edge that arrives mid-conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)                                proto_err_o <= 1'b0;
        else if (start_edge && state != ST_TRACK)  proto_err_o <= 1'b1;
    end

    // R8
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |=> !fifo_wr_o);

    // R8
    wr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> track_o);

    // R9
    proto_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o);

    // R4
    range_no_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_trial_o |-> (!fifo_wr_o && !track_o));
endmodule

// File: tb/sar_sequencer_tb_top.sv
// Directed bench for sar_sequencer: one task per scenario.
module sar_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        cmp;
    logic [11:0] trial;
    logic        rng;
    logic [11:0] result;
    logic        oor;
    logic        fifo_wr;
    logic        track;
    logic        proto;

    logic [11:0] tgt = 12'h000;
    logic        beyond = 1'b0;
    int          errors = 0;
    int          checks = 0;

    always #4 clk = ~clk;

    // Comparator model: held input at or above the trial level; range trial
    // answers with the bench's "beyond span" flag.
    assign cmp = rng ? beyond : (trial <= tgt);

    sar_sequencer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .cs_n          (cs_n),
        .rd_n          (rd_n),
        .wr_n          (wr_n),
        .cmp_i         (cmp),
        .trial_code_o  (trial),
        .range_trial_o (rng),
        .result_o      (result),
        .result_oor_o  (oor),
        .fifo_wr_o     (fifo_wr),
        .track_o       (track),
        .proto_err_o   (proto)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bus active in the low phase before edge (start edge + r).
    function automatic bit bus_at(input int mode, input int r);
        case (mode)
            1, 6, 7: return (r == 4);
            2:       return (r >= 4 && r <= 8);
            3:       return (r >= 4 && (r % 5) == 4);
            4:       return (r == 2 || r == 3);
            5:       return (r >= 53 && r <= 56);
            default: return 1'b0;
        endcase
    endfunction

    task automatic apply_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
    endtask

    // Runs one conversion and checks timing, result, range flag and pulse.
    task automatic run_conv(input logic [11:0] v, input bit bey, input int mode,
                            input int slips, input string req);
        bit found = 1'b0;
        int seen  = 0;
        logic [11:0] exp_res = v ^ 12'h800;
        bit exp_oor = bey && (v == 12'h000 || v == 12'hFFF);
        tgt = v;
        beyond = bey;
        @(posedge clk); #1;
        start_i = 1'b1;
        for (int n = 1; n <= 150 && !found; n++) begin
            @(posedge clk); #1;
            if (n == 3) start_i = 1'b0;
            if (mode == 8 && n == 20) start_i = 1'b1;
            if (mode == 8 && n == 22) start_i = 1'b0;
            cs_n = !(bus_at(mode, n) && mode != 7);
            rd_n = !(bus_at(mode, n) && mode != 6);
            wr_n = !(bus_at(mode, n) && mode == 6);
            if (n == 2) begin
                chk(trial == 12'h800, "R2", "trial code after start", trial, 12'h800);
                chk(track == 1'b0, "R2", "track after start", track, 0);
            end
            #1;
            if (fifo_wr) begin
                found = 1'b1;
                seen  = n;
            end
        end
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        chk(found && seen == 57 + slips, req, "clock of fifo write", seen, 57 + slips);
        chk(result == exp_res, "R3", "result", result, exp_res);
        chk(oor == exp_oor, "R4", "range flag", oor, exp_oor);
        chk(track == 1'b1, "R8", "track with write", track, 1);
        @(posedge clk); #2;
        chk(fifo_wr == 1'b0, "R8", "write pulse length", fifo_wr, 0);
    endtask

    task automatic t_reset();
        apply_reset();
        chk(track == 1'b1, "R1", "track at reset", track, 1);
        chk(fifo_wr == 1'b0, "R1", "fifo_wr at reset", fifo_wr, 0);
        chk(proto == 1'b0, "R1", "proto at reset", proto, 0);
        chk(result == 12'h000 && oor == 1'b0, "R1", "result at reset", result, 0);
    endtask

    task automatic t_proto();
        run_conv(12'h3C5, 1'b0, 8, 0, "R9");
        chk(proto == 1'b1, "R9", "proto flag set", proto, 1);
        repeat (5) @(posedge clk);
        #2;
        chk(proto == 1'b1, "R9", "proto flag sticky", proto, 1);
        apply_reset();
        chk(proto == 1'b0, "R9", "proto cleared by reset", proto, 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        run_conv(12'h5A3, 1'b0, 0, 0,  "R5");   // idle bus, 56 clocks
        run_conv(12'h800, 1'b0, 0, 0,  "R5");   // mid-scale
        run_conv(12'h7FF, 1'b1, 0, 0,  "R4");   // range flag off mid-scale
        run_conv(12'hFFF, 1'b1, 1, 1,  "R6");   // top end, one read slip
        run_conv(12'hFFF, 1'b0, 0, 0,  "R4");   // top end, in range
        run_conv(12'h000, 1'b1, 2, 5,  "R6");   // bottom end, five-clock slip
        run_conv(12'h9E1, 1'b0, 3, 13, "R6");   // every decision slips
        run_conv(12'h124, 1'b0, 6, 1,  "R6");   // write access slips too
        run_conv(12'h456, 1'b0, 4, 0,  "R7");   // access between decisions
        run_conv(12'hABC, 1'b0, 5, 0,  "R7");   // access during transfer
        run_conv(12'h321, 1'b0, 7, 0,  "R7");   // chip select high
        chk(proto == 1'b0, "R9", "no proto without overlap", proto, 0);
        t_proto();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule